// File: doc/BRIEF.md
# Write-Once Time-Windowed Configuration Register

An 8-bit system configuration register with a byte-wide write and read port. It also has a mode input that selects normal or special operation. Some fields can be changed at any time. Four protected fields are accepted only once after reset, and only while a short window counted from reset release is still open. After that they are frozen until the next reset.

In special mode the protection is lifted, and the protected fields may be rewritten at any time. The block drives its current contents on a dedicated output for the rest of the chip. It also raises a lock flag whenever the protected fields can no longer be changed.

Field layout, bit 7 down to bit 0: `ana_pwr`, `clk_alt`, `irq_edge`, `osc_wait`, `clk_mon`, unused bit 2, `wdog_rate[1:0]`. The protected bits are 5, 4, 1 and 0, which is mask 0x33. The free bits are 7, 6 and 3, which is mask 0xC8.

Top module: `cfg_guard_reg`

## Requirements
- R1: While reset is asserted and just after its release, `cfg_q` equals 0x10 (only bit 4 set) and `locked` is 0.
- R2: A write (`cs`=1, `wr_en`=1) always loads bits 7, 6 and 3 from `wdata` on the next clock edge, in either mode and whether or not the protected bits are locked.
- R3: Bit 2 of `cfg_q` and of `rdata` always reads 0, whatever is written.
- R4: In normal mode, the first write whose clock edge is one of the first 64 edges after reset release loads bits 5, 4, 1 and 0 from `wdata`, together with the free bits of the same write.
- R5: In normal mode, after that first accepted write, later writes leave bits 5, 4, 1 and 0 unchanged.
- R6: In normal mode, a write on edge 64 or later after reset release leaves bits 5, 4, 1 and 0 unchanged. The window never reopens, however long the block runs.
- R7: In special mode (`special_mode`=1), every write loads bits 5, 4, 1 and 0, any number of times and at any time. Special-mode writes do not use up the single normal-mode write.
- R8: `locked` is 1 exactly when `special_mode` is 0 and either a normal-mode protected write has been accepted or the 64-edge window has closed.
- R9: Without `cs` the register does not change, and `rdata` is 0. With `cs`=1, `rdata` shows the register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| special_mode | input | 1 | 1 selects special mode (protection lifted) |
| cs | input | 1 | Register select |
| wr_en | input | 1 | Write strobe, effective with `cs` |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when `cs` is low |
| cfg_q | output | 8 | Current register contents |
| locked | output | 1 | Protected bits currently frozen |

## Verification
The main function is exercised with several write sequences. A first write early in the window shows that the free and protected fields load together. Repeat writes with inverted data separate the one-shot lock from a write that was simply ignored. Writes on edge 63 and on edge 64 after release pin down the exact end of the window. A long idle stretch followed by a write shows that the window does not reopen. Alternating special and normal writes with distinct patterns shows that special mode bypasses the lock without using up the single write, and that the lock flag follows the mode input.

// File: rtl/cfg_guard_pkg.sv
// Package: shared widths, field positions and masks of the guarded
// configuration register. Assumes an 8-bit register layout.
package cfg_guard_pkg;
    localparam int unsigned CFG_W = 8;

    // Bit positions
    localparam int unsigned B_ANA_PWR  = 7;
    localparam int unsigned B_CLK_ALT  = 6;
    localparam int unsigned B_IRQ_EDGE = 5;
    localparam int unsigned B_OSC_WAIT = 4;
    localparam int unsigned B_CLK_MON  = 3;
    localparam int unsigned B_UNUSED   = 2;

    // Protected fields: irq_edge, osc_wait, wdog_rate[1:0]
    localparam logic [CFG_W-1:0] PROT_MASK  = 8'h33;
    // Always-writable fields: ana_pwr, clk_alt, clk_mon
    localparam logic [CFG_W-1:0] FREE_MASK  = 8'hC8;
    localparam logic [CFG_W-1:0] RESET_VAL  = 8'h10;
endpackage

// File: rtl/cfg_window_timer.sv
// Module: counts clock edges since reset release and reports whether the
// protected-write window is still open. Saturates at WINDOW so it never
// wraps. Assumes synchronous active-low reset.
module cfg_window_timer #(
    parameter int unsigned WINDOW = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic window_open
);
    localparam int unsigned CNT_W = $clog2(WINDOW + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WINDOW);

    logic [CNT_W-1:0] cnt;

    // Purpose: saturating count of edges since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end

    assign window_open = (cnt != CNT_MAX);

    p_cnt_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_MAX);
    p_window_stays_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !window_open |=> !window_open);
endmodule

// File: rtl/cfg_lock_tracker.sv
// Module: remembers that the one allowed normal-mode protected write has
// happened. Cleared only by reset. Assumes the caller qualifies the
// accepted write.
module cfg_lock_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic prot_wr_taken,
    output logic wr_done
);
    // Purpose: sticky flag set by the first accepted normal-mode write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_done <= 1'b0;
        else if (prot_wr_taken)
            wr_done <= 1'b1;
    end

    p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> wr_done);
endmodule

// File: rtl/cfg_guard_reg.sv
// Module: 8-bit configuration register. Free fields are writable at any time.
// Protected fields take one write within WINDOW edges of reset release in
// normal mode, and any number of writes in special mode.
// Assumes cs/wr_en come from an address decoder synchronous to clk.
module cfg_guard_reg
    import cfg_guard_pkg::*;
#(
    parameter int unsigned WINDOW = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             special_mode,
    input  logic             cs,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output logic [CFG_W-1:0] cfg_q,
    output logic             locked
);
    logic window_open;
    logic wr_done;
    logic wr_hit;
    logic prot_ok;
    logic [CFG_W-1:0] wr_mask;

    cfg_window_timer #(.WINDOW(WINDOW)) i_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .window_open (window_open)
    );

    cfg_lock_tracker i_lock (
        .clk           (clk),
        .rst_n         (rst_n),
        .prot_wr_taken (wr_hit && !special_mode && prot_ok),
        .wr_done       (wr_done)
    );

    // Purpose: decide which bits a write may touch this cycle.
    always_comb begin
        wr_hit  = cs && wr_en;
        prot_ok = special_mode || (!wr_done && window_open);
        wr_mask = FREE_MASK | (prot_ok ? PROT_MASK : '0);
    end

    // Purpose: register storage with per-bit write masking.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= RESET_VAL;
        else if (wr_hit)
            cfg_q <= (cfg_q & ~wr_mask) | (wdata & wr_mask);
    end

    assign locked = !special_mode && (wr_done || !window_open);
    assign rdata  = cs ? cfg_q : '0;

    p_bit2_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[B_UNUSED] == 1'b0);
    p_prot_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !special_mode) |=> $stable(cfg_q & PROT_MASK));
    p_nocs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> $stable(cfg_q));
    p_free_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr_en) |=> ((cfg_q & FREE_MASK) == ($past(wdata) & FREE_MASK)));
endmodule

// File: tb/test_cfg_guard_reg.sv
module test_cfg_guard_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       special_mode = 1'b0;
    logic       cs = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] cfg_q;
    logic       locked;

    int checks = 0;
    int errors = 0;
    int edge_n = 0;

    logic [7:0] m_cfg;
    logic       m_done;

    typedef struct {
        logic [7:0] val;
        logic       lck;
        string      tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    cfg_guard_reg i_cfg_guard_reg (
        .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
        .cs(cs), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .cfg_q(cfg_q), .locked(locked)
    );

    // bench-side count of edges since reset release
    always @(posedge clk) begin
        if (!rst_n) edge_n <= 0;
        else if (edge_n < 100000) edge_n <= edge_n + 1;
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compare scoreboard items just after each edge
    always @(posedge clk) begin
        #1;
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check({it.tag, " cfg_q"}, cfg_q, it.val);
            check({it.tag, " locked"}, {7'd0, locked}, {7'd0, it.lck});
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cs = 0; wr_en = 0;
        repeat (2) @(negedge clk);
        check("R1 reset cfg_q", cfg_q, 8'h10);
        check("R1 reset locked", {7'd0, locked}, 8'h00);
        rst_n = 1'b1;
        m_cfg = 8'h10; m_done = 1'b0;
    endtask

    // driver: one bus cycle; model computes expectation, pushes it
    task automatic drive(input logic c, input logic w, input logic [7:0] d,
                         input logic sp, input string tag);
        item_t it;
        logic ok;
        int idx;
        @(negedge clk);
        cs = c; wr_en = w; wdata = d; special_mode = sp;
        idx = edge_n;
        ok = sp || (!m_done && idx < 64);
        if (c && w) begin
            m_cfg = (m_cfg & 8'h33 & ~{8{ok}}) | (d & 8'hC8) | (ok ? (d & 8'h33) : 8'h00);
            if (m_cfg[7] === 1'bx) m_cfg = 8'h00;
            if (ok && !sp) m_done = 1'b1;
        end
        m_cfg = m_cfg & 8'hFB;
        it.val = m_cfg;
        it.lck = !sp && (m_done || (idx + 1) >= 64);
        it.tag = tag;
        @(posedge clk);
        sb.push_back(it);
    endtask

    task automatic idle_until(input int target);
        while (edge_n < target) begin
            @(negedge clk);
            cs = 0; wr_en = 0;
            if (edge_n >= target) break;
            @(posedge clk);
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        drive(0, 1, 8'hFF, 0, "R9 write without cs");
        @(negedge clk); cs = 0; wr_en = 0; #1;
        check("R9 rdata cs low", rdata, 8'h00);
        drive(1, 1, 8'h37, 0, "R4 R3 first write in window");
        drive(1, 1, 8'hFF, 0, "R5 R2 later write free only");
        drive(1, 1, 8'h00, 0, "R5 R2 clear free bits");
        @(negedge clk); cs = 1; wr_en = 0; #1;
        check("R9 rdata cs high", rdata, 8'h33);
        check("R3 R8 locked after write", {7'd0, locked}, 8'h01);

        do_reset();
        idle_until(63);
        drive(1, 1, 8'h03, 0, "R4 write on edge 63");
        do_reset();
        idle_until(64);
        drive(1, 1, 8'hFB, 0, "R6 write on edge 64");
        drive(1, 1, 8'h24, 1, "R7 special write 1");
        drive(1, 1, 8'h11, 1, "R7 special write 2");
        drive(1, 0, 8'h00, 1, "R8 special unlock");
        drive(1, 0, 8'h00, 0, "R8 normal relock");
        idle_until(900);
        drive(1, 1, 8'h33, 0, "R6 no reopen after long idle");

        do_reset();
        drive(1, 1, 8'h22, 1, "R7 special in window");
        drive(1, 1, 8'h01, 0, "R7 R4 normal write still allowed");
        drive(1, 1, 8'h32, 0, "R5 second normal write blocked");
        @(negedge clk); cs = 0; wr_en = 0;
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule